// File: doc/BRIEF.md
# Coin-Credit Drink Vending Controller

This block is a synchronous, state-only-output (Moore) controller for a drink dispenser that costs 35 cents. Each clock cycle it samples a 2-bit coin code: nickel, dime, quarter or nothing. It keeps the money inserted so far as an internal credit value, which can stand at any multiple of 5 cents from 0 up to 30.

When an inserted coin brings the credit to 35 cents or more, the controller asserts a one-cycle vend pulse. It then pays back the overpayment one coin per cycle on a 2-bit refund output that uses the same code as the coin input, largest coin first. After the last refund coin it goes back to collecting with zero credit. Coins offered while a sale or refund is in progress are not credited.

The coin unit, the price and the coin weights are parameters. Elaboration checks reject any weight set for which the refund could fail to settle exactly.

Top module: `vend_ctrl`

## Requirements
- R1: An active-high asynchronous reset at any time forces vend_o low, chg_o to 00 and the credit to zero, without waiting for a clock edge.
- R2: The coin code is 00 = none, 01 = nickel (5 cents), 10 = dime (10 cents), 11 = quarter (25 cents). Coins add to the credit, and vend_o and chg_o stay low while the credit is below 35 cents.
- R3: A cycle with coin code 00 while collecting leaves the credit unchanged and keeps both outputs quiet.
- R4: The coin that brings the credit to 35 cents or more causes vend_o to go high in the following cycle, for exactly one cycle.
- R5: The excess above 35 cents is returned on chg_o one coin per cycle, using the same coin code, starting in the cycle after the vend pulse. Each coin is the largest that fits in the remaining excess: 20 gives dime, dime; 15 gives dime, nickel; 10 gives dime; 5 gives nickel.
- R6: For every coin sequence, the cents returned on chg_o plus 35 equal the cents inserted for that sale.
- R7: Coin codes presented during the vend cycle or during refund cycles are ignored and never credited.
- R8: vend_o and a non-zero chg_o never occur in the same cycle. After the last refund coin the controller collects again from zero credit.
- R9: An exact payment of 35 cents produces the vend pulse and no refund coin, and the next cycle accepts coins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| coin_i | input | 2 | Inserted coin code, held for one cycle per coin |
| vend_o | output | 1 | One-cycle dispense pulse |
| chg_o | output | 2 | Refund coin code, one coin per cycle, 00 when idle |

## Verification
The bench builds the controller with its default parameters: a 5-cent unit, a price of 7 units, and coin weights of 1, 2 and 5 units. With these values the largest possible overpayment, 20 cents (30 cents of credit plus a quarter), can be reached, so every refund length from zero to two coins is exercised. All 81 orderings of four non-empty coins are played through a credit model in the bench, so sales complete at every reachable credit level. Quarters are also pushed during vend and refund cycles; afterwards the bench proves the credit was not disturbed by completing an exact-price sale.

// File: rtl/vend_pkg.sv
package vend_pkg;

   typedef enum logic [1:0] {
      COIN_NONE    = 2'b00,
      COIN_NICKEL  = 2'b01,
      COIN_DIME    = 2'b10,
      COIN_QUARTER = 2'b11
   } coin_e;

   typedef enum logic [1:0] {
      PH_COLLECT = 2'b00,
      PH_VEND    = 2'b01,
      PH_REFUND  = 2'b10
   } phase_e;

   localparam int NUM_KINDS = 3;

endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value #(
   parameter int CW            = 4,
   parameter int NICKEL_UNITS  = 1,
   parameter int DIME_UNITS    = 2,
   parameter int QUARTER_UNITS = 5
) (
   input  logic [1:0]    code,
   output logic [CW-1:0] units
);
   import vend_pkg::*;

   always_comb begin
      case (code)
         COIN_NICKEL:  units = CW'(NICKEL_UNITS);
         COIN_DIME:    units = CW'(DIME_UNITS);
         COIN_QUARTER: units = CW'(QUARTER_UNITS);
         default:      units = '0;
      endcase
   end

endmodule

// File: rtl/vend_credit_acc.sv
module vend_credit_acc #(
   parameter int CW          = 4,
   parameter int PRICE_UNITS = 7
) (
   input  logic [CW-1:0] credit,
   input  logic [CW-1:0] add,
   output logic [CW-1:0] sum,
   output logic          reached,
   output logic [CW-1:0] excess
);
   localparam logic [CW-1:0] PRICE_W = CW'(PRICE_UNITS);

   always_comb begin
      sum     = credit + add;
      reached = (sum >= PRICE_W);
      excess  = reached ? (sum - PRICE_W) : '0;
   end

endmodule

// File: rtl/vend_change_sel.sv
module vend_change_sel #(
   parameter int CW            = 4,
   parameter int NICKEL_UNITS  = 1,
   parameter int DIME_UNITS    = 2,
   parameter int QUARTER_UNITS = 5
) (
   input  logic [CW-1:0] remain,
   output logic [1:0]    code,
   output logic [CW-1:0] units
);
   import vend_pkg::*;

   localparam logic [CW-1:0] KIND_UNITS [NUM_KINDS] = '{
      CW'(NICKEL_UNITS), CW'(DIME_UNITS), CW'(QUARTER_UNITS)
   };
   localparam logic [1:0] KIND_CODE [NUM_KINDS] = '{
      COIN_NICKEL, COIN_DIME, COIN_QUARTER
   };

   logic [NUM_KINDS-1:0] fits;

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_fit
      assign fits[k] = (remain >= KIND_UNITS[k]);
   end

   // Kinds are ordered by increasing value; the last fitting one wins.
   always_comb begin
      code  = COIN_NONE;
      units = '0;
      for (int k = 0; k < NUM_KINDS; k++) begin
         if (fits[k]) begin
            code  = KIND_CODE[k];
            units = KIND_UNITS[k];
         end
      end
   end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
   parameter int PRICE_UNITS   = 7,
   parameter int NICKEL_UNITS  = 1,
   parameter int DIME_UNITS    = 2,
   parameter int QUARTER_UNITS = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] coin_i,
   output logic       vend_o,
   output logic [1:0] chg_o
);
   import vend_pkg::*;

   localparam int MAX_UNITS = PRICE_UNITS - 1 + QUARTER_UNITS;
   localparam int CW        = $clog2(MAX_UNITS + 1);

   if (NICKEL_UNITS != 1) begin : g_bad_nickel
      $error("vend_ctrl: smallest coin must weigh one unit");
   end
   if (!(DIME_UNITS > NICKEL_UNITS && QUARTER_UNITS > DIME_UNITS)) begin : g_bad_order
      $error("vend_ctrl: coin weights must increase nickel < dime < quarter");
   end
   if (PRICE_UNITS < 1) begin : g_bad_price
      $error("vend_ctrl: price must be at least one unit");
   end

   phase_e        phase_q;
   logic [CW-1:0] credit_q;
   logic [CW-1:0] coin_units;
   logic [CW-1:0] sum_units;
   logic [CW-1:0] excess_units;
   logic          reached;
   logic [1:0]    pick_code;
   logic [CW-1:0] pick_units;

   vend_coin_value #(
      .CW(CW), .NICKEL_UNITS(NICKEL_UNITS),
      .DIME_UNITS(DIME_UNITS), .QUARTER_UNITS(QUARTER_UNITS)
   ) u_value (
      .code  (coin_i),
      .units (coin_units)
   );

   vend_credit_acc #(
      .CW(CW), .PRICE_UNITS(PRICE_UNITS)
   ) u_acc (
      .credit  (credit_q),
      .add     (coin_units),
      .sum     (sum_units),
      .reached (reached),
      .excess  (excess_units)
   );

   vend_change_sel #(
      .CW(CW), .NICKEL_UNITS(NICKEL_UNITS),
      .DIME_UNITS(DIME_UNITS), .QUARTER_UNITS(QUARTER_UNITS)
   ) u_sel (
      .remain (credit_q),
      .code   (pick_code),
      .units  (pick_units)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         phase_q  <= PH_COLLECT;
         credit_q <= '0;
      end else begin
         case (phase_q)
            PH_COLLECT: begin
               if (coin_i != COIN_NONE) begin
                  if (reached) begin
                     phase_q  <= PH_VEND;
                     credit_q <= excess_units;
                  end else begin
                     credit_q <= sum_units;
                  end
               end
            end
            PH_VEND: begin
               phase_q <= (credit_q == '0) ? PH_COLLECT : PH_REFUND;
            end
            PH_REFUND: begin
               credit_q <= credit_q - pick_units;
               if (credit_q == pick_units) phase_q <= PH_COLLECT;
            end
            default: begin
               phase_q  <= PH_COLLECT;
               credit_q <= '0;
            end
         endcase
      end
   end

   assign vend_o = (phase_q == PH_VEND);
   assign chg_o  = (phase_q == PH_REFUND) ? pick_code : COIN_NONE;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
   parameter int CW        = 4,
   parameter int MAX_UNITS = 11
) (
   input logic          clk,
   input logic          rst,
   input logic [1:0]    coin_i,
   input logic          vend_o,
   input logic [1:0]    chg_o,
   input logic [CW-1:0] credit
);

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      !(vend_o && chg_o != 2'b00)); // R8

   AST_VEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      vend_o |=> !vend_o); // R4

   AST_VEND_FROM_COIN: assert property (@(posedge clk) disable iff (rst)
      $rose(vend_o) |-> ($past(coin_i) != 2'b00)); // R4

   AST_REFUND_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (chg_o != 2'b00) |-> ($past(vend_o) || $past(chg_o) != 2'b00)); // R5

   AST_REFUND_DESCENDS: assert property (@(posedge clk) disable iff (rst)
      (chg_o != 2'b00) |=> (chg_o == 2'b00 || chg_o <= $past(chg_o))); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (coin_i == 2'b00 && !vend_o && chg_o == 2'b00) |=> (!vend_o && chg_o == 2'b00)); // R3

   AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
      credit <= CW'(MAX_UNITS)); // R2

endmodule

bind vend_ctrl vend_ctrl_chk #(.CW(CW), .MAX_UNITS(MAX_UNITS)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .coin_i (coin_i),
   .vend_o (vend_o),
   .chg_o  (chg_o),
   .credit (credit_q)
);

// File: tb/sim_vend_ctrl.sv
`timescale 1ns/1ps
module sim_vend_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] coin_i = 2'b00;
   logic       vend_o;
   logic [1:0] chg_o;

   int errors = 0;
   int checks = 0;
   int credit_c = 0;

   always #5 clk = ~clk;

   vend_ctrl u0 (
      .clk    (clk),
      .rst    (rst),
      .coin_i (coin_i),
      .vend_o (vend_o),
      .chg_o  (chg_o)
   );

   function automatic int cents(input logic [1:0] c);
      case (c)
         2'b01:   return 5;
         2'b10:   return 10;
         2'b11:   return 25;
         default: return 0;
      endcase
   endfunction

   function automatic logic [1:0] greedy(input int rem);
      if (rem >= 25) return 2'b11;
      if (rem >= 10) return 2'b10;
      if (rem >= 5)  return 2'b01;
      return 2'b00;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // At the negedge right after the completing coin was sampled.
   task automatic observe(input int exp_cents, input bit junk, input string tag);
      int rem = exp_cents;
      int got = 0;
      logic [1:0] expc;
      chk(vend_o == 1'b1, "R4", int'(vend_o), 1, {tag, " vend pulse"});
      chk(chg_o == 2'b00, "R8", int'(chg_o), 0, {tag, " no change with vend"});
      coin_i = junk ? 2'b11 : 2'b00;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         expc = greedy(rem);
         chk(chg_o == expc, "R5", int'(chg_o), int'(expc), {tag, " refund coin"});
         chk(vend_o == 1'b0, "R4", int'(vend_o), 0, {tag, " vend single cycle"});
         if (chg_o == 2'b00) begin
            coin_i = 2'b00;
            break;
         end
         got += cents(chg_o);
         rem -= cents(expc);
         coin_i = junk ? 2'b11 : 2'b00;
      end
      coin_i = 2'b00;
      chk(got == exp_cents, "R6", got, exp_cents, {tag, " refund total"});
   endtask

   task automatic pay(input logic [1:0] code, input bit junk, input string tag);
      @(negedge clk);
      coin_i = code;
      credit_c += cents(code);
      @(negedge clk);
      coin_i = 2'b00;
      if (credit_c >= 35) begin
         observe(credit_c - 35, junk, tag);
         credit_c = 0;
      end else begin
         chk(vend_o == 1'b0, "R2", int'(vend_o), 0, {tag, " no vend below price"});
         chk(chg_o == 2'b00, "R2", int'(chg_o), 0, {tag, " no change below price"});
      end
   endtask

   task automatic t_reset();
      chk(vend_o == 1'b0 && chg_o == 2'b00, "R1", int'({vend_o, chg_o}), 0, "outputs in reset");
      pay(2'b10, 1'b0, "reset_mid");
      #2 rst = 1'b1;
      #1 chk(vend_o == 1'b0 && chg_o == 2'b00, "R1", int'({vend_o, chg_o}), 0, "async reset outputs");
      @(negedge clk);
      rst = 1'b0;
      credit_c = 0;
      for (int i = 0; i < 6; i++) pay(2'b01, 1'b0, "R1 credit cleared");
      pay(2'b01, 1'b0, "R1 seventh nickel");
   endtask

   task automatic t_exact();
      pay(2'b11, 1'b0, "R9 q+d");
      pay(2'b10, 1'b0, "R9 q+d");
      pay(2'b01, 1'b0, "R9 next sale");
      pay(2'b10, 1'b0, "R9 next sale");
      pay(2'b10, 1'b0, "R9 next sale");
      pay(2'b10, 1'b0, "R9 next sale");
   endtask

   task automatic t_refunds();
      pay(2'b01, 1'b0, "R5 n q q");
      pay(2'b11, 1'b0, "R5 n q q");
      pay(2'b11, 1'b0, "R5 n q q");
      pay(2'b11, 1'b0, "R5 q q");
      pay(2'b11, 1'b0, "R5 q q");
      pay(2'b10, 1'b0, "R5 d d q");
      pay(2'b10, 1'b0, "R5 d d q");
      pay(2'b11, 1'b0, "R5 d d q");
      for (int i = 0; i < 6; i++) pay(2'b01, 1'b0, "R5 6n d");
      pay(2'b10, 1'b0, "R5 6n d");
   endtask

   task automatic t_idle();
      pay(2'b10, 1'b0, "R3 dime");
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(vend_o == 1'b0 && chg_o == 2'b00, "R3", int'({vend_o, chg_o}), 0, "idle quiet");
      end
      pay(2'b11, 1'b0, "R3 held credit exact");
   endtask

   task automatic t_ignore();
      pay(2'b11, 1'b1, "R7 q q junk");
      pay(2'b11, 1'b1, "R7 q q junk");
      pay(2'b10, 1'b0, "R7 credit zero");
      pay(2'b10, 1'b0, "R7 credit zero");
      pay(2'b10, 1'b0, "R7 credit zero");
      pay(2'b01, 1'b0, "R7 R8 exact after refund");
   endtask

   task automatic t_sweep();
      logic [1:0] seq [4];
      for (int s = 0; s < 81; s++) begin
         int v = s;
         for (int j = 0; j < 4; j++) begin
            seq[j] = 2'((v % 3) + 1);
            v = v / 3;
         end
         for (int j = 0; j < 4; j++) pay(seq[j], 1'b0, "R6 sweep");
      end
      while (credit_c != 0) pay(2'b01, 1'b0, "R6 sweep flush");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_exact();
      t_refunds();
      t_idle();
      t_ignore();
      t_sweep();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule